// File: doc/BRIEF.md
# Masked-Match Memory Bank Decoder

This block works out which of four logical memory banks owns a physical address. Each bank holds a small configuration word, written through a simple register port. The word has an enable bit, a match value and a don't-care mask for a high address slice, and a match value and a don't-care mask for a low address slice. An address belongs to a bank when the bank is enabled and every address bit that differs from the match value in either slice is marked don't-care by that slice's mask. The low slice selects the interleave way, and the high slice selects the region.

A lookup request carries one physical address. One clock later the block returns a valid strobe, a hit or miss flag, the local number of the first bank that claims the address, and a global bank number built from the controller's port number. For every bank the block also gives the geometry it infers from the masks: a base address, an interleave factor and a bank size. The positions and widths of the slices are parameters.

Top module: `bank_decoder`

## Requirements
- R1: A bank whose enable bit is 0 never claims an address, even when both of its masks are all ones.
- R2: The high slice is address bits [42:32], zero-extended to the 12-bit match and mask width. A high-slice bit that differs from the high match value blocks a hit unless the same bit of the high mask is 1 (don't-care).
- R3: The low slice is address bits [9:6], 4 bits wide. A low-slice bit that differs from the low match value blocks a hit unless the same bit of the low mask is 1.
- R4: A bank claims an address only when both the high and the low comparisons pass.
- R5: When several banks claim an address, the lowest-numbered one is reported.
- R6: On a hit, the global bank number `res_gid` equals 4 × `port_id` + the local bank number. The port number is sampled with the request.
- R7: Results appear on the clock edge after `lk_req` is high, with `res_valid` high for exactly that cycle. Without a request, `res_valid` is 0 and the result outputs keep their values.
- R8: On a miss, `res_miss` is 1, `res_hit` is 0, and `res_bank` and `res_gid` are 0. On a hit, `res_hit` is 1 and `res_miss` is 0.
- R9: The interleave factor comes from the low mask: 0xF gives 1, 0xE gives 2, 0xC gives 4, 0x8 gives 8 and 0x0 gives 16. Every other mask value gives 1.
- R10: A bank's base address is (high match AND NOT high mask) shifted left by 32.
- R11: A bank's size is (high mask bits [9:0] + 1) shifted left by 32, then divided by the interleave factor. High mask bits 10 and 11 do not affect the size.
- R12: After reset all banks are disabled with all-zero fields, so every bank reports base 0, interleave 16 and size 0x1000_0000. All result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for one bank's configuration |
| cfg_sel | input | 2 | Bank being written |
| cfg_en | input | 1 | Enable bit to write |
| cfg_hi_mask | input | 12 | High-slice don't-care mask to write |
| cfg_hi_match | input | 12 | High-slice match value to write |
| cfg_lo_mask | input | 4 | Low-slice don't-care mask to write |
| cfg_lo_match | input | 4 | Low-slice match value to write |
| port_id | input | 5 | Controller port number |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 43 | Physical address to look up |
| res_valid | output | 1 | One-cycle strobe marking a new result |
| res_hit | output | 1 | A bank claimed the address |
| res_miss | output | 1 | No bank claimed the address |
| res_bank | output | 2 | Local number of the claiming bank |
| res_gid | output | 7 | Global bank number |
| bank_base | output | 176 | Base addresses, 44 bits per bank, bank 0 in the low bits |
| bank_ilv | output | 20 | Interleave factors, 5 bits per bank |
| bank_size | output | 172 | Bank sizes, 43 bits per bank |

## Verification
Assertions run on every cycle and check the following properties. The result strobe follows each request by one cycle, and results hold between requests. Hit and miss are mutually exclusive, and a miss drives the bank and global number outputs to zero. The reported bank is the lowest one that claims the address, and that bank is enabled. The global number always combines the sampled port number with the reported bank. A full-zero low mask always gives the widest interleave. Whether the mask comparisons are correct bit by bit, and what base and size a given configuration produces, can only be shown by the bench's scenarios. Those scenarios include disabled banks with all-don't-care masks, single-bit mismatches covered or not covered by the mask, overlapping banks, the unlisted low-mask codes, and the size bits that must be ignored.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;
   localparam int unsigned HI_W = 12;
   localparam int unsigned LO_W = 4;

   typedef struct packed {
      logic            en;
      logic [HI_W-1:0] hi_mask;
      logic [HI_W-1:0] hi_match;
      logic [LO_W-1:0] lo_mask;
      logic [LO_W-1:0] lo_match;
   } bank_cfg_t;
endpackage

// File: rtl/bdec_cfg_regs.sv
module bdec_cfg_regs
   import bank_dec_pkg::*;
#(
   parameter int unsigned NBANK = 4,
   localparam int unsigned SEL_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [SEL_W-1:0]       sel,
   input  bank_cfg_t              wdata,
   output bank_cfg_t [NBANK-1:0]  cfg_q
);
   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_q[b] <= '0;
         end else if (we && (sel == SEL_W'(b))) begin
            cfg_q[b] <= wdata;
         end
      end
   end
endmodule

// File: rtl/bdec_match.sv
module bdec_match
   import bank_dec_pkg::*;
#(
   parameter int unsigned PA_W     = 43,
   parameter int unsigned HI_SHIFT = 32,
   parameter int unsigned LO_SHIFT = 6,
   localparam int unsigned HA_W    = PA_W - HI_SHIFT
) (
   input  bank_cfg_t        cfg,
   input  logic [PA_W-1:0]  addr,
   output logic             hit
);
   logic [HI_W-1:0] hi_field;
   logic [LO_W-1:0] lo_field;
   logic [HI_W-1:0] hi_bad;
   logic [LO_W-1:0] lo_bad;

   if (HA_W > HI_W) begin : g_bad_width
      $error("high address slice wider than match field");
   end

   always_comb begin
      hi_field = HI_W'(addr[PA_W-1:HI_SHIFT]);
      lo_field = addr[LO_SHIFT +: LO_W];
      // bits that differ and are not excused by the mask
      hi_bad   = (hi_field ^ cfg.hi_match) & ~cfg.hi_mask;
      lo_bad   = (lo_field ^ cfg.lo_match) & ~cfg.lo_mask;
      hit      = cfg.en && (hi_bad == '0) && (lo_bad == '0);
   end
endmodule

// File: rtl/bdec_geom.sv
module bdec_geom
   import bank_dec_pkg::*;
#(
   parameter int unsigned HI_SHIFT = 32,
   parameter int unsigned SZ_BITS  = 10,
   localparam int unsigned BASE_W  = HI_W + HI_SHIFT,
   localparam int unsigned SZ_W    = SZ_BITS + 1 + HI_SHIFT,
   localparam int unsigned ILV_W   = LO_W + 1,
   localparam int unsigned ISH_W   = $clog2(LO_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bank_cfg_t         cfg,
   output logic [BASE_W-1:0] base,
   output logic [ILV_W-1:0]  ilv,
   output logic [SZ_W-1:0]   size
);
   logic [ISH_W-1:0] ish;
   logic [SZ_W-1:0]  span;

   if (SZ_BITS > HI_W) begin : g_bad_sz
      $error("size bits exceed high mask width");
   end

   // low mask with k trailing zeros and ones above selects 2**k ways
   always_comb begin
      ish = '0;
      for (int k = 0; k <= int'(LO_W); k++) begin
         if (cfg.lo_mask == LO_W'({LO_W{1'b1}} << k)) ish = ISH_W'(k);
      end
   end

   always_comb begin
      ilv  = ILV_W'(1) << ish;
      base = BASE_W'(cfg.hi_match & ~cfg.hi_mask) << HI_SHIFT;
      span = (SZ_W'(cfg.hi_mask[SZ_BITS-1:0]) + SZ_W'(1)) << HI_SHIFT;
      size = span >> ish;
   end

   p_full_ilv_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.lo_mask == '0) |-> (ilv == ILV_W'(1) << LO_W));

   p_size_nz_r11: assert property (@(posedge clk) disable iff (!rst_n)
      size != '0);
endmodule

// File: rtl/bdec_prio.sv
module bdec_prio #(
   parameter int unsigned NBANK = 4,
   localparam int unsigned SEL_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NBANK-1:0]  hits,
   output logic              any,
   output logic [SEL_W-1:0]  idx
);
   always_comb begin
      any = |hits;
      idx = '0;
      for (int i = int'(NBANK) - 1; i >= 0; i--) begin
         if (hits[i]) idx = SEL_W'(i);
      end
   end

   p_first_claims_r5: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> hits[idx]);

   p_none_below_r5: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> ((hits & ((NBANK'(1) << idx) - NBANK'(1))) == '0));
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
   import bank_dec_pkg::*;
#(
   parameter int unsigned NBANK    = 4,
   parameter int unsigned PA_W     = 43,
   parameter int unsigned HI_SHIFT = 32,
   parameter int unsigned LO_SHIFT = 6,
   parameter int unsigned SZ_BITS  = 10,
   parameter int unsigned PID_W    = 5,
   localparam int unsigned SEL_W   = (NBANK > 1) ? $clog2(NBANK) : 1,
   localparam int unsigned GID_W   = PID_W + SEL_W,
   localparam int unsigned BASE_W  = HI_W + HI_SHIFT,
   localparam int unsigned SZ_W    = SZ_BITS + 1 + HI_SHIFT,
   localparam int unsigned ILV_W   = LO_W + 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [SEL_W-1:0]          cfg_sel,
   input  logic                      cfg_en,
   input  logic [HI_W-1:0]           cfg_hi_mask,
   input  logic [HI_W-1:0]           cfg_hi_match,
   input  logic [LO_W-1:0]           cfg_lo_mask,
   input  logic [LO_W-1:0]           cfg_lo_match,
   input  logic [PID_W-1:0]          port_id,
   input  logic                      lk_req,
   input  logic [PA_W-1:0]           lk_addr,
   output logic                      res_valid,
   output logic                      res_hit,
   output logic                      res_miss,
   output logic [SEL_W-1:0]          res_bank,
   output logic [GID_W-1:0]          res_gid,
   output logic [NBANK*BASE_W-1:0]   bank_base,
   output logic [NBANK*ILV_W-1:0]    bank_ilv,
   output logic [NBANK*SZ_W-1:0]     bank_size
);
   if ((NBANK & (NBANK - 1)) != 0) begin : g_bad_nbank
      $error("bank count must be a power of two");
   end
   if (LO_SHIFT + LO_W > HI_SHIFT || HI_SHIFT >= PA_W) begin : g_bad_slices
      $error("address slices overlap or exceed address width");
   end

   bank_cfg_t              wdata;
   bank_cfg_t [NBANK-1:0]  cfg_q;
   logic [NBANK-1:0]       hits;
   logic                   any;
   logic [SEL_W-1:0]       idx;

   assign wdata = '{en: cfg_en, hi_mask: cfg_hi_mask, hi_match: cfg_hi_match,
                    lo_mask: cfg_lo_mask, lo_match: cfg_lo_match};

   bdec_cfg_regs #(.NBANK(NBANK)) i_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
      .wdata(wdata), .cfg_q(cfg_q)
   );

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      bdec_match #(.PA_W(PA_W), .HI_SHIFT(HI_SHIFT), .LO_SHIFT(LO_SHIFT)) i_match (
         .cfg(cfg_q[b]), .addr(lk_addr), .hit(hits[b])
      );
      bdec_geom #(.HI_SHIFT(HI_SHIFT), .SZ_BITS(SZ_BITS)) i_geom (
         .clk(clk), .rst_n(rst_n), .cfg(cfg_q[b]),
         .base(bank_base[b*BASE_W +: BASE_W]),
         .ilv(bank_ilv[b*ILV_W +: ILV_W]),
         .size(bank_size[b*SZ_W +: SZ_W])
      );
   end

   bdec_prio #(.NBANK(NBANK)) i_prio (
      .clk(clk), .rst_n(rst_n), .hits(hits), .any(any), .idx(idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
         res_miss  <= 1'b0;
         res_bank  <= '0;
         res_gid   <= '0;
      end else begin
         res_valid <= lk_req;
         if (lk_req) begin
            res_hit  <= any;
            res_miss <= !any;
            res_bank <= any ? idx : '0;
            res_gid  <= any ? {port_id, idx} : '0;
         end
      end
   end

   p_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> res_valid);

   p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |=> (!res_valid && $stable(res_bank) && $stable(res_gid) && $stable(res_hit)));

   p_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_hit != res_miss));

   p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_miss) |-> (res_bank == '0 && res_gid == '0));

   p_gid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req && any) |=> (res_gid == {$past(port_id), res_bank}));

   p_enabled_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> cfg_q[idx].en);
endmodule

// File: tb/test_bank_decoder.sv
module test_bank_decoder;
   localparam int BASE_W = 44;
   localparam int ILV_W  = 5;
   localparam int SZ_W   = 43;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic        cfg_en = 1'b0;
   logic [11:0] cfg_hi_mask = '0, cfg_hi_match = '0;
   logic [3:0]  cfg_lo_mask = '0, cfg_lo_match = '0;
   logic [4:0]  port_id = '0;
   logic        lk_req = 1'b0;
   logic [42:0] lk_addr = '0;
   logic        res_valid, res_hit, res_miss;
   logic [1:0]  res_bank;
   logic [6:0]  res_gid;
   logic [4*BASE_W-1:0] bank_base;
   logic [4*ILV_W-1:0]  bank_ilv;
   logic [4*SZ_W-1:0]   bank_size;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   bank_decoder i_bank_decoder (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_en(cfg_en),
      .cfg_hi_mask(cfg_hi_mask), .cfg_hi_match(cfg_hi_match),
      .cfg_lo_mask(cfg_lo_mask), .cfg_lo_match(cfg_lo_match),
      .port_id(port_id), .lk_req(lk_req), .lk_addr(lk_addr),
      .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
      .res_bank(res_bank), .res_gid(res_gid),
      .bank_base(bank_base), .bank_ilv(bank_ilv), .bank_size(bank_size)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [42:0] mk_addr(input logic [10:0] hi, input logic [3:0] lo);
      return {hi, 22'd0, lo, 6'd0};
   endfunction

   task automatic wr_bank(input logic [1:0] b, input logic en, input logic [11:0] hm,
                          input logic [11:0] hv, input logic [3:0] lm, input logic [3:0] lv);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = b; cfg_en = en;
      cfg_hi_mask = hm; cfg_hi_match = hv; cfg_lo_mask = lm; cfg_lo_match = lv;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // expects result at the negedge following the capturing posedge
   task automatic lookup(input string tag, input logic [42:0] a,
                         input logic exp_hit, input logic [1:0] exp_bank);
      logic [6:0] eg;
      @(negedge clk);
      lk_req = 1'b1; lk_addr = a;
      @(negedge clk);
      lk_req = 1'b0;
      eg = exp_hit ? 7'(port_id * 4 + exp_bank) : 7'd0;
      chk({tag, " R7 valid"}, 64'(res_valid), 64'd1);
      chk({tag, " R8 hit"},   64'(res_hit),   64'(exp_hit));
      chk({tag, " R8 miss"},  64'(res_miss),  64'(!exp_hit));
      chk({tag, " bank"},     64'(res_bank),  64'(exp_bank));
      chk({tag, " R6 gid"},   64'(res_gid),   64'(eg));
   endtask

   task automatic t_reset;
      chk("R12 valid", 64'(res_valid), 0);
      chk("R12 hit", 64'(res_hit), 0);
      chk("R12 miss", 64'(res_miss), 0);
      chk("R12 gid", 64'(res_gid), 0);
      for (int b = 0; b < 4; b++) begin
         chk("R12 base", 64'(bank_base[b*BASE_W +: BASE_W]), 0);
         chk("R12 ilv", 64'(bank_ilv[b*ILV_W +: ILV_W]), 16);
         chk("R12 size", 64'(bank_size[b*SZ_W +: SZ_W]), 64'h1000_0000);
      end
      lookup("R12 lookup", mk_addr(11'h0, 4'h0), 1'b0, 2'd0);
   endtask

   task automatic t_disabled;
      wr_bank(0, 1'b0, 12'hFFF, 12'h000, 4'hF, 4'h0);
      lookup("R1 disabled", mk_addr(11'h3A5, 4'h7), 1'b0, 2'd0);
      wr_bank(0, 1'b1, 12'hFFF, 12'h000, 4'hF, 4'h0);
      lookup("R1 enabled", mk_addr(11'h3A5, 4'h7), 1'b1, 2'd0);
      wr_bank(0, 1'b0, 12'h000, 12'h000, 4'h0, 4'h0);
   endtask

   task automatic t_upper;
      wr_bank(1, 1'b1, 12'h000, 12'h005, 4'hF, 4'h0);
      lookup("R2 exact", mk_addr(11'h005, 4'h3), 1'b1, 2'd1);
      lookup("R2 bit0 differs", mk_addr(11'h004, 4'h3), 1'b0, 2'd0);
      lookup("R2 bit10 differs", mk_addr(11'h405, 4'h3), 1'b0, 2'd0);
      wr_bank(1, 1'b1, 12'h001, 12'h005, 4'hF, 4'h0);
      lookup("R2 bit0 masked", mk_addr(11'h004, 4'h3), 1'b1, 2'd1);
      // high match bit 11 set while address bit is always zero
      wr_bank(1, 1'b1, 12'h000, 12'h805, 4'hF, 4'h0);
      lookup("R2 bit11 unreachable", mk_addr(11'h005, 4'h3), 1'b0, 2'd0);
      wr_bank(1, 1'b0, 12'h000, 12'h000, 4'h0, 4'h0);
   endtask

   task automatic t_lower;
      wr_bank(2, 1'b1, 12'h7FF, 12'h000, 4'h0, 4'hA);
      lookup("R3 exact", mk_addr(11'h123, 4'hA), 1'b1, 2'd2);
      lookup("R3 differs", mk_addr(11'h123, 4'hB), 1'b0, 2'd0);
      wr_bank(2, 1'b1, 12'h7FF, 12'h000, 4'h1, 4'hA);
      lookup("R3 masked", mk_addr(11'h123, 4'hB), 1'b1, 2'd2);
      // R4: high passes, low fails; then low passes, high fails
      wr_bank(2, 1'b1, 12'h000, 12'h010, 4'h0, 4'h6);
      lookup("R4 high only", mk_addr(11'h010, 4'h7), 1'b0, 2'd0);
      lookup("R4 low only", mk_addr(11'h011, 4'h6), 1'b0, 2'd0);
      lookup("R4 both", mk_addr(11'h010, 4'h6), 1'b1, 2'd2);
   endtask

   task automatic t_priority;
      port_id = 5'd21;
      wr_bank(1, 1'b1, 12'hFFF, 12'h000, 4'hF, 4'h0);
      wr_bank(3, 1'b1, 12'hFFF, 12'h000, 4'hF, 4'h0);
      lookup("R5 lowest of 1,2,3", mk_addr(11'h010, 4'h6), 1'b1, 2'd1);
      wr_bank(0, 1'b1, 12'hFFF, 12'h000, 4'hF, 4'h0);
      lookup("R5 R6 bank0 wins", mk_addr(11'h010, 4'h6), 1'b1, 2'd0);
      wr_bank(0, 1'b0, 12'h0, 12'h0, 4'h0, 4'h0);
      wr_bank(1, 1'b0, 12'h0, 12'h0, 4'h0, 4'h0);
      wr_bank(2, 1'b0, 12'h0, 12'h0, 4'h0, 4'h0);
      lookup("R6 bank3 gid", mk_addr(11'h2AA, 4'h1), 1'b1, 2'd3);
      chk("R6 gid value", 64'(res_gid), 64'd87);
   endtask

   task automatic t_hold_and_miss;
      repeat (3) @(negedge clk);
      chk("R7 no strobe", 64'(res_valid), 0);
      chk("R7 bank held", 64'(res_bank), 3);
      chk("R7 hit held", 64'(res_hit), 1);
      wr_bank(3, 1'b0, 12'h0, 12'h0, 4'h0, 4'h0);
      lookup("R8 miss after hit", mk_addr(11'h2AA, 4'h1), 1'b0, 2'd0);
      @(negedge clk);
      chk("R7 strobe one cycle", 64'(res_valid), 0);
   endtask

   task automatic t_interleave;
      logic [3:0] codes [6] = '{4'hF, 4'hE, 4'hC, 4'h8, 4'h0, 4'h5};
      logic [4:0] ways  [6] = '{5'd1, 5'd2, 5'd4, 5'd8, 5'd16, 5'd1};
      for (int i = 0; i < 6; i++) begin
         wr_bank(2, 1'b0, 12'h000, 12'h000, codes[i], 4'h0);
         @(negedge clk);
         chk("R9 ilv", 64'(bank_ilv[2*ILV_W +: ILV_W]), 64'(ways[i]));
      end
   endtask

   task automatic t_geometry;
      wr_bank(1, 1'b1, 12'h00F, 12'h123, 4'hF, 4'h0);
      @(negedge clk);
      chk("R10 base", 64'(bank_base[1*BASE_W +: BASE_W]), 64'h120 << 32);
      chk("R11 size", 64'(bank_size[1*SZ_W +: SZ_W]), 64'h10 << 32);
      wr_bank(1, 1'b1, 12'hC03, 12'hFFF, 4'hC, 4'h0);
      @(negedge clk);
      chk("R10 base masked", 64'(bank_base[1*BASE_W +: BASE_W]), 64'h3FC << 32);
      chk("R11 size top bits ignored", 64'(bank_size[1*SZ_W +: SZ_W]), 64'h1 << 32);
      wr_bank(1, 1'b1, 12'h3FF, 12'h000, 4'h0, 4'h0);
      @(negedge clk);
      chk("R11 max size /16", 64'(bank_size[1*SZ_W +: SZ_W]), 64'h400 << 28);
   endtask

   initial begin
      #500000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_disabled();
      t_upper();
      t_lower();
      t_priority();
      t_hold_and_miss();
      t_interleave();
      t_geometry();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule